// File: doc/BRIEF.md
# Angular Rate Sample Conditioner

This block takes one raw signed angular-rate sample per axis for a two-axis rate sensor, together with a raw temperature code, and turns them into the words that a register readout path presents to the host. The two axis samples can be exchanged, a small signed user offset is converted into output counts and added per axis, the result is clamped to the 16-bit signed range, and each axis can be negated. The temperature code is left-justified into a 16-bit word. All three words are then split into bytes in the order the host selects.

The offset is scaled according to the full-scale setting. At the fine range it is worth 257 output counts per offset step. At the coarse range it is worth 128 counts per step. The two axis slots apply the offset with opposite polarity: the first slot subtracts it and the second slot adds it. The block has one register stage. A sample accepted with `in_valid` appears on `rd_bytes` one clock later, and the outputs hold between accepted samples.

Top module: `rate_cond_top`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and all of `rd_bytes` are zero after that edge.
- R2: A sample presented with `in_valid`=1 at a clock edge appears on `rd_bytes` with `out_valid`=1 after that edge. When `in_valid`=0 at an edge, `out_valid` is 0 after it and `rd_bytes` keeps its previous value, whatever the data and configuration inputs hold.
- R3: `rd_bytes` carries six bytes. Byte k sits at bits [8k+7:8k], and k is the readout address. Bytes 0-1 hold the temperature word, bytes 2-3 hold the first axis slot, and bytes 4-5 hold the second axis slot. With `cfg_swap`=0 the first slot is built from `raw_x` and the second from `raw_y`; with `cfg_swap`=1 the two sources are exchanged. The offset and inversion controls belong to the slot, not to the source.
- R4: With `cfg_fs`=0, the first slot adds −257×`cfg_off_x` and the second slot adds +257×`cfg_off_y`. The offsets are 7-bit two's-complement values.
- R5: With `cfg_fs`=1, the scale factor is 128 instead of 257, with the same polarities as in R4.
- R6: The sum of the sample and the scaled offset saturates to [−32768, 32767] instead of wrapping.
- R7: `cfg_inv_x` and `cfg_inv_y` negate the saturated first and second slot results. Negating −32768 gives 32767.
- R8: With `cfg_msb_first`=0, the even byte of each word is its low byte and the odd byte is its high byte. With `cfg_msb_first`=1, the even byte is the high byte.
- R9: The temperature word is `raw_temp` (12-bit two's complement) in bits 15:4 with bits 3:0 zero. Swap, offset, scale and inversion settings do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the current sample |
| raw_x | input | 16 | Raw X rate sample, signed |
| raw_y | input | 16 | Raw Y rate sample, signed |
| raw_temp | input | 12 | Raw temperature code, signed |
| cfg_swap | input | 1 | Exchange axis sources |
| cfg_inv_x | input | 1 | Negate first slot |
| cfg_inv_y | input | 1 | Negate second slot |
| cfg_fs | input | 1 | Full-scale select: 0 fine (×257), 1 coarse (×128) |
| cfg_msb_first | input | 1 | High byte at the even address |
| cfg_off_x | input | 7 | First slot offset, signed |
| cfg_off_y | input | 7 | Second slot offset, signed |
| out_valid | output | 1 | Registered result updated this cycle |
| rd_bytes | output | 48 | Six readout bytes, byte k at [8k+7:8k] |

## Verification
The bench targets several corner cases, each of which a wrong design would show in a specific way.

- **Offset polarity.** Equal offsets applied to both slots must move them in opposite directions. A design that uses one sign for both slots shows the wrong value in one slot.
- **Scale factor.** Both the ×257 and ×128 steps are checked. A design that ties the scale to the wrong full-scale setting gives values that are off by a multiple of the offset.
- **Saturation.** Sums are driven past both limits. A wrapping adder would show the opposite sign.
- **Inversion of the most negative value.** Negating −32768 must give 32767. A plain negation leaves it at −32768.
- **Swap and inversion order.** With swap set, the slot's own controls must still apply. A design that binds them to the source instead fails this case.
- **Byte order.** The byte order is checked for every word.
- **Temperature isolation.** The temperature word must be immune to the axis controls. A design that lets them leak in shows a changed temperature word.
- **Hold between samples.** The outputs must not change when new data arrives without `in_valid`. A design that follows the inputs every cycle fails this case.

// File: rtl/rate_cond_pkg.sv
package rate_cond_pkg;
  parameter int SAMPLE_W   = 16;
  parameter int TEMP_W     = 12;
  parameter int OFFS_W     = 7;
  parameter int BYTE_W     = 8;
  parameter int N_WORDS    = 3;
  parameter int GAIN_FINE  = 257;
  parameter int GAIN_COARSE = 128;
  localparam int GAIN_W    = $clog2(GAIN_FINE + 1);
  localparam int CORR_W    = OFFS_W + GAIN_W + 1;
  localparam int OUT_W     = N_WORDS * SAMPLE_W;
  // word slots in readout order (address pairs)
  typedef enum logic [1:0] {
    SLOT_TEMP = 2'd0,
    SLOT_A    = 2'd1,
    SLOT_B    = 2'd2
  } slot_e;
endpackage

// File: rtl/rc_offset_scale.sv
module rc_offset_scale #(
  parameter int OFFS_W = 7,
  parameter int CORR_W = 17,
  parameter int GAIN_FINE = 257,
  parameter int GAIN_COARSE = 128,
  parameter bit NEGATE = 1'b0
) (
  input  logic signed [OFFS_W-1:0] off,
  input  logic                     coarse,
  output logic signed [CORR_W-1:0] corr
);
  logic signed [CORR_W-1:0] off_ext;
  logic signed [CORR_W-1:0] gain_s;
  logic signed [CORR_W-1:0] prod;

  assign off_ext = {{(CORR_W-OFFS_W){off[OFFS_W-1]}}, off};
  assign gain_s  = coarse ? CORR_W'(GAIN_COARSE) : CORR_W'(GAIN_FINE);
  assign prod    = off_ext * gain_s;

  generate
    if (NEGATE) begin : g_neg
      assign corr = -prod;
    end else begin : g_pos
      assign corr = prod;
    end
  endgenerate
endmodule

// File: rtl/rc_axis_path.sv
module rc_axis_path #(
  parameter int SAMPLE_W = 16,
  parameter int CORR_W = 17
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [CORR_W-1:0]   corr,
  input  logic                       invert,
  output logic signed [SAMPLE_W-1:0] result
);
  localparam int WIDE_W = ((SAMPLE_W > CORR_W) ? SAMPLE_W : CORR_W) + 2;
  localparam logic signed [WIDE_W-1:0] MAXV =
    {{(WIDE_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] MINV =
    {{(WIDE_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

  logic signed [WIDE_W-1:0] sum_w, clip_w, neg_w, fin_w;

  always_comb begin
    sum_w = {{(WIDE_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample}
          + {{(WIDE_W-CORR_W){corr[CORR_W-1]}}, corr};
    if (sum_w > MAXV)      clip_w = MAXV;
    else if (sum_w < MINV) clip_w = MINV;
    else                   clip_w = sum_w;
    neg_w = -clip_w;
    if (!invert)           fin_w = clip_w;
    else if (neg_w > MAXV) fin_w = MAXV;
    else                   fin_w = neg_w;
    result = fin_w[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/rc_byte_map.sv
module rc_byte_map #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int N_WORDS = 3
) (
  input  logic [N_WORDS*WORD_W-1:0] words,
  input  logic                      msb_first,
  output logic [N_WORDS*WORD_W-1:0] bytes_out
);
  generate
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      logic [BYTE_W-1:0] lo_b, hi_b;
      assign lo_b = words[w*WORD_W +: BYTE_W];
      assign hi_b = words[w*WORD_W+BYTE_W +: BYTE_W];
      assign bytes_out[w*WORD_W +: BYTE_W]        = msb_first ? hi_b : lo_b;
      assign bytes_out[w*WORD_W+BYTE_W +: BYTE_W] = msb_first ? lo_b : hi_b;
    end
  endgenerate
endmodule

// File: rtl/rate_cond_top.sv
module rate_cond_top
  import rate_cond_pkg::*;
#(
  parameter int P_SAMPLE_W = SAMPLE_W,
  parameter int P_TEMP_W   = TEMP_W,
  parameter int P_OFFS_W   = OFFS_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic signed [P_SAMPLE_W-1:0]  raw_x,
  input  logic signed [P_SAMPLE_W-1:0]  raw_y,
  input  logic signed [P_TEMP_W-1:0]    raw_temp,
  input  logic                          cfg_swap,
  input  logic                          cfg_inv_x,
  input  logic                          cfg_inv_y,
  input  logic                          cfg_fs,
  input  logic                          cfg_msb_first,
  input  logic signed [P_OFFS_W-1:0]    cfg_off_x,
  input  logic signed [P_OFFS_W-1:0]    cfg_off_y,
  output logic                          out_valid,
  output logic [N_WORDS*P_SAMPLE_W-1:0] rd_bytes
);
  localparam int TOT_W  = N_WORDS * P_SAMPLE_W;
  localparam int PAD_W  = P_SAMPLE_W - P_TEMP_W;
  localparam int C_W    = P_OFFS_W + GAIN_W + 1;

  logic signed [P_SAMPLE_W-1:0] src_a, src_b, res_a, res_b;
  logic signed [C_W-1:0]        corr_a, corr_b;
  logic [TOT_W-1:0]             words, mapped;

  // step 1: axis exchange
  assign src_a = cfg_swap ? raw_y : raw_x;
  assign src_b = cfg_swap ? raw_x : raw_y;

  // step 2: offset scaling, opposite polarity per slot
  rc_offset_scale #(.OFFS_W(P_OFFS_W), .CORR_W(C_W), .GAIN_FINE(GAIN_FINE),
                    .GAIN_COARSE(GAIN_COARSE), .NEGATE(1'b1)) u_scale_a (
    .off(cfg_off_x), .coarse(cfg_fs), .corr(corr_a));
  rc_offset_scale #(.OFFS_W(P_OFFS_W), .CORR_W(C_W), .GAIN_FINE(GAIN_FINE),
                    .GAIN_COARSE(GAIN_COARSE), .NEGATE(1'b0)) u_scale_b (
    .off(cfg_off_y), .coarse(cfg_fs), .corr(corr_b));

  // steps 3/4: saturating add, then optional negation
  rc_axis_path #(.SAMPLE_W(P_SAMPLE_W), .CORR_W(C_W)) u_path_a (
    .sample(src_a), .corr(corr_a), .invert(cfg_inv_x), .result(res_a));
  rc_axis_path #(.SAMPLE_W(P_SAMPLE_W), .CORR_W(C_W)) u_path_b (
    .sample(src_b), .corr(corr_b), .invert(cfg_inv_y), .result(res_b));

  always_comb begin
    words = '0;
    words[int'(SLOT_TEMP)*P_SAMPLE_W +: P_SAMPLE_W] = {raw_temp, {PAD_W{1'b0}}};
    words[int'(SLOT_A)*P_SAMPLE_W +: P_SAMPLE_W]    = res_a;
    words[int'(SLOT_B)*P_SAMPLE_W +: P_SAMPLE_W]    = res_b;
  end

  rc_byte_map #(.WORD_W(P_SAMPLE_W), .BYTE_W(BYTE_W), .N_WORDS(N_WORDS)) u_map (
    .words(words), .msb_first(cfg_msb_first), .bytes_out(mapped));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      rd_bytes  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) rd_bytes <= mapped;
    end
  end
endmodule

// File: rtl/rate_cond_chk.sv
module rate_cond_chk (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic signed [15:0] raw_x,
  input logic               cfg_swap,
  input logic               cfg_inv_x,
  input logic               cfg_msb_first,
  input logic signed [6:0]  cfg_off_x,
  input logic               out_valid,
  input logic [47:0]        rd_bytes
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && rd_bytes == '0));

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(rd_bytes)));

  p_pass_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cfg_swap && cfg_off_x == 7'sd0 && !cfg_inv_x && !cfg_msb_first)
    |=> rd_bytes[31:16] == $past(raw_x));

  p_invert_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cfg_swap && cfg_off_x == 7'sd0 && cfg_inv_x && !cfg_msb_first)
    |=> rd_bytes[31:16] == (($past(raw_x) == 16'sh8000) ? 16'sh7fff : -$past(raw_x)));

  p_temp_nibble_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cfg_msb_first) |=> rd_bytes[3:0] == 4'h0);
endmodule

bind rate_cond_top rate_cond_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .raw_x(raw_x),
  .cfg_swap(cfg_swap), .cfg_inv_x(cfg_inv_x), .cfg_msb_first(cfg_msb_first),
  .cfg_off_x(cfg_off_x), .out_valid(out_valid), .rd_bytes(rd_bytes));

// File: tb/rate_cond_top_tb_top.sv
module rate_cond_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] raw_x = '0, raw_y = '0;
  logic signed [11:0] raw_temp = '0;
  logic cfg_swap = 0, cfg_inv_x = 0, cfg_inv_y = 0, cfg_fs = 0, cfg_msb_first = 0;
  logic signed [6:0] cfg_off_x = '0, cfg_off_y = '0;
  logic out_valid;
  logic [47:0] rd_bytes;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rate_cond_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .raw_x(raw_x), .raw_y(raw_y),
    .raw_temp(raw_temp), .cfg_swap(cfg_swap), .cfg_inv_x(cfg_inv_x),
    .cfg_inv_y(cfg_inv_y), .cfg_fs(cfg_fs), .cfg_msb_first(cfg_msb_first),
    .cfg_off_x(cfg_off_x), .cfg_off_y(cfg_off_y), .out_valid(out_valid),
    .rd_bytes(rd_bytes));

  function automatic int clampv(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [15:0] order16(logic [15:0] w, bit mf);
    return mf ? {w[7:0], w[15:8]} : w;
  endfunction

  function automatic logic [47:0] model(int rx, int ry, int rt, bit sw, bit ix,
                                         bit iy, bit fs, bit mf, int ox, int oy);
    int a, b, k, sa, sb;
    logic [15:0] w0, w1, w2;
    a = sw ? ry : rx;
    b = sw ? rx : ry;
    k = fs ? 128 : 257;
    sa = clampv(a - ox * k);
    if (ix) sa = clampv(-sa);
    sb = clampv(b + oy * k);
    if (iy) sb = clampv(-sb);
    w0 = {rt[11:0], 4'h0};
    w1 = sa[15:0];
    w2 = sb[15:0];
    return {order16(w2, mf), order16(w1, mf), order16(w0, mf)};
  endfunction

  task automatic check(string req, logic [47:0] got, logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(int rx, int ry, int rt, bit sw, bit ix, bit iy, bit fs,
                       bit mf, int ox, int oy);
    @(negedge clk);
    raw_x = 16'(rx); raw_y = 16'(ry); raw_temp = 12'(rt);
    cfg_swap = sw; cfg_inv_x = ix; cfg_inv_y = iy; cfg_fs = fs;
    cfg_msb_first = mf; cfg_off_x = 7'(ox); cfg_off_y = 7'(oy);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_model(string req, int rx, int ry, int rt, bit sw, bit ix,
                           bit iy, bit fs, bit mf, int ox, int oy);
    apply(rx, ry, rt, sw, ix, iy, fs, mf, ox, oy);
    check(req, {47'b0, out_valid}, 48'd1);
    check(req, rd_bytes, model(rx, ry, rt, sw, ix, iy, fs, mf, ox, oy));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset", {out_valid, rd_bytes}, '0);
    rst = 1'b0;
    apply(1234, -99, 5, 0, 0, 0, 0, 0, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset after data", {out_valid, rd_bytes}, '0);
    rst = 1'b0;
  endtask

  task automatic t_pass;
    run_model("R2 pass", 1000, -2000, 16, 0, 0, 0, 0, 0, 0, 0);
    check("R3 x slot", {32'b0, rd_bytes[31:16]}, 48'(16'sd1000));
    check("R3 y slot", {32'b0, rd_bytes[47:32]}, 48'(16'hF830));
  endtask

  task automatic t_hold;
    logic [47:0] snap;
    run_model("R2 load", 321, 654, -7, 0, 0, 0, 0, 0, 3, 4);
    snap = rd_bytes;
    @(negedge clk);
    raw_x = 16'sd9; raw_y = 16'sd9; cfg_swap = 1; cfg_msb_first = 1; cfg_off_x = 7'sd20;
    @(negedge clk);
    check("R2 hold bytes", rd_bytes, snap);
    check("R2 hold valid", {47'b0, out_valid}, 48'd0);
  endtask

  task automatic t_swap;
    run_model("R3 swap", 111, -222, 0, 1, 0, 0, 0, 0, 0, 0);
    check("R3 swapped x slot", {32'b0, rd_bytes[31:16]}, 48'(16'hFF22));
    run_model("R3 swap slot controls", 500, 300, 0, 1, 1, 0, 0, 0, 1, 1);
    // first slot = 300 - 257 = 43, negated -> -43
    check("R3 slot owns controls", {32'b0, rd_bytes[31:16]}, 48'(16'hFFD5));
  endtask

  task automatic t_offset;
    run_model("R4 fine", 1000, 1000, 0, 0, 0, 0, 0, 0, 1, 1);
    check("R4 fine x=743", {32'b0, rd_bytes[31:16]}, 48'(16'd743));
    check("R4 fine y=1257", {32'b0, rd_bytes[47:32]}, 48'(16'd1257));
    run_model("R4 fine neg", 0, 0, 0, 0, 0, 0, 0, 0, -64, -64);
    run_model("R5 coarse", 1000, 1000, 0, 0, 0, 0, 1, 0, 1, 1);
    check("R5 coarse x=872", {32'b0, rd_bytes[31:16]}, 48'(16'd872));
    check("R5 coarse y=1128", {32'b0, rd_bytes[47:32]}, 48'(16'd1128));
    run_model("R5 coarse ext", -500, 500, 0, 0, 0, 0, 1, 0, 63, -64);
  endtask

  task automatic t_sat;
    run_model("R6 sat", 32700, -32700, 0, 0, 0, 0, 0, 0, -64, -64);
    check("R6 high clamp", {32'b0, rd_bytes[31:16]}, 48'(16'h7FFF));
    check("R6 low clamp", {32'b0, rd_bytes[47:32]}, 48'(16'h8000));
    run_model("R6 sat coarse", -32000, 32000, 0, 0, 0, 0, 1, 0, 63, 63);
  endtask

  task automatic t_invert;
    run_model("R7 invert", 1500, -1500, 0, 0, 1, 1, 0, 0, 0, 0);
    run_model("R7 invert min", -32768, -32768, 0, 0, 1, 1, 0, 0, 0, 0);
    check("R7 min to max", {32'b0, rd_bytes[31:16]}, 48'(16'h7FFF));
    run_model("R7 after offset", 100, 100, 0, 0, 1, 1, 0, 0, 2, 2);
    check("R7 x=-(100-514)", {32'b0, rd_bytes[31:16]}, 48'(16'd414));
  endtask

  task automatic t_endian;
    run_model("R8 lsb first", 16'h1234, 16'h5678, 12'hABC, 0, 0, 0, 0, 0, 0, 0);
    check("R8 byte2 low", {40'b0, rd_bytes[23:16]}, 48'h34);
    run_model("R8 msb first", 16'h1234, 16'h5678, 12'hABC, 0, 0, 0, 0, 1, 0, 0);
    check("R8 byte2 high", {40'b0, rd_bytes[23:16]}, 48'h12);
    check("R8 temp byte0 high", {40'b0, rd_bytes[7:0]}, 48'hAB);
  endtask

  task automatic t_temp;
    run_model("R9 temp", 0, 0, -1, 0, 0, 0, 0, 0, 0, 0);
    check("R9 temp word", {32'b0, rd_bytes[15:0]}, 48'hFFF0);
    run_model("R9 isolate", 200, 300, 12'h7F3, 1, 1, 1, 1, 0, -30, 40);
    check("R9 temp isolated", {32'b0, rd_bytes[15:0]}, 48'h7F30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_pass();
    t_hold();
    t_swap();
    t_offset();
    t_sat();
    t_invert();
    t_endian();
    t_temp();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule